// File: doc/BRIEF.md
# Burst Read Return Stage

This block is the last stage of a memory read path. After the array side has corrected each 8-byte word, it loads the word into a small shift buffer. The buffer is 64 bits wide and four entries deep. Each word carries a flag that marks an uncorrectable error. A read burst is 1, 2 or 4 words long. At the start of a burst, a start pulse gives the length code. The array side also raises an early-warning strobe one clock before each load.

One clock before the final word of the burst is loaded, the block requests the system bus. It keeps the request up until the arbiter grants it. Once the grant has been seen and every word is in the buffer, a set/reset enable flop turns on the bus drive. A read select then starts at zero and steps through the buffered words, oldest first. Each word passes through a final output register, and the bus enable lines up with that register. The enable is cleared after the last word has been presented, so the bus is driven for exactly as many clocks as the burst has words.

A board-disable input keeps the enable flop cleared and suppresses the request. In that case a burst is still consumed silently, so the block stays ready for the next one.

Top module: `burst_return`

## Requirements
- R1: While reset is asserted, and until the first burst, `bus_oe_o`, `bus_req_o`, `bus_data_o` and `bus_uerr_o` are all 0. Reset is asserted asynchronously, and its release is synchronised over two clocks.
- R2: A load strobe shifts the buffer by one entry only while a burst is being filled and is not yet complete. A load strobe at any other time, including during bus drive, has no effect on the returned data.
- R3: The length code maps to a word count as follows: code 0 gives 1 word, code 1 gives 2, code 2 gives 4, and code 3 saturates to 4. The words come out on the bus in the order they were loaded.
- R4: `bus_req_o` is high in the cycle where the early-warning strobe `pre_i` is high and exactly one word of the burst is still to be loaded. It stays high until a grant is taken. It is never high outside a burst fill.
- R5: A grant counts only while `bus_req_o` is high, and it is remembered. If the grant comes while the buffer is already full, `bus_oe_o` rises on the next clock. If the grant comes early, `bus_oe_o` rises on the clock after the final word has been loaded.
- R6: `bus_oe_o` stays high for exactly as many consecutive clocks as the burst has words. In each of those clocks, `bus_data_o` holds the word for that position in the burst.
- R7: While `board_dis_i` is high, `bus_req_o` is 0 and, from the next clock on, `bus_oe_o` is 0. A burst filled under disable is drained without drive, so the next burst behaves normally.
- R8: Each word's uncorrectable flag appears on `bus_uerr_o` in the same clock as that word. A flagged word does not shorten the burst.
- R9: A start pulse that arrives while a burst is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins a burst; samples `len_i` |
| len_i | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:4 words) |
| pre_i | input | 1 | Early warning, one clock before a load strobe |
| ld_i | input | 1 | Load strobe for a corrected word |
| ld_data_i | input | DW | Corrected word |
| ld_uerr_i | input | 1 | Uncorrectable-error flag for the loaded word |
| board_dis_i | input | 1 | Holds bus drive and request off |
| bus_gnt_i | input | 1 | Grant from the bus arbiter |
| bus_req_o | output | 1 | Bus request |
| bus_oe_o | output | 1 | Bus data enable |
| bus_data_o | output | DW | Registered word on the bus |
| bus_uerr_o | output | 1 | Uncorrectable flag for the word on the bus |

## Verification
The bench builds the block with its defaults, DW of 64 and DEPTH of 4. With a four-entry buffer, every length code can be reached, including the saturating code 3, and the read index is exercised from the deepest entry down to the newest. The wide data word lets each word carry a per-burst seed and its own position, so any reordering or stale entry shows up directly. The grant timing is tested with an early grant, a grant on the next clock and grants that come later.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FILL  = 2'd1,
    PH_DRAIN = 2'd2
  } phase_t;
endpackage

// File: rtl/br_shift_buf.sv
module br_shift_buf #(
  parameter int DW    = 64,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int EW   = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic [DW-1:0] din_i,
  input  logic          dflag_i,
  input  logic [AW-1:0] rd_idx_i,
  output logic [DW-1:0] dout_o,
  output logic          dflag_o
);
  logic [EW-1:0] ent   [DEPTH];
  logic [EW-1:0] ent_n [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head
      assign ent_n[i] = {dflag_i, din_i};
    end else begin : g_body
      assign ent_n[i] = ent[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent[i] <= '0;
      end else if (shift_i) begin
        ent[i] <= ent_n[i];
      end
    end
  end

  assign {dflag_o, dout_o} = ent[rd_idx_i];
endmodule

// File: rtl/br_seq.sv
module br_seq
  import br_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LENW  = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [LENW-1:0] len_i,
  input  logic            pre_i,
  input  logic            ld_i,
  input  logic            board_dis_i,
  input  logic            bus_gnt_i,
  output logic            shift_o,
  output logic            bus_req_o,
  output logic [AW-1:0]   rd_idx_o,
  output logic            step_o,
  output logic            launch_o,
  output logic            done_o
);
  phase_t         phase_q, phase_n;
  logic [CW-1:0]  words_q, words_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic [CW-1:0]  sel_q, sel_n;
  logic           req_q, req_n;
  logic           granted_q, granted_n;

  logic           fill, drain, pre_hit, gnt_take, gnt_pend, all_in, more;
  logic [CW-1:0]  idx_full;

  function automatic logic [CW-1:0] words_of(input logic [LENW-1:0] code);
    if (int'(code) >= AW) return CW'(DEPTH);
    return CW'(1) << code;
  endfunction

  assign fill     = (phase_q == PH_FILL);
  assign drain    = (phase_q == PH_DRAIN);
  assign all_in   = (cnt_q == words_q);
  assign shift_o  = fill && ld_i && !all_in;
  assign pre_hit  = fill && pre_i && (cnt_q == words_q - CW'(1));
  assign bus_req_o = (pre_hit || req_q) && !granted_q && !board_dis_i;
  assign gnt_take = bus_gnt_i && bus_req_o;
  assign gnt_pend = granted_q || gnt_take;
  assign launch_o = fill && all_in && (gnt_pend || board_dis_i);
  assign more     = drain && (sel_q < words_q);
  assign done_o   = drain && (sel_q == words_q);
  assign step_o   = launch_o || more;
  assign idx_full = words_q - CW'(1) - (launch_o ? CW'(0) : sel_q);
  assign rd_idx_o = idx_full[AW-1:0];

  always_comb begin
    phase_n   = phase_q;
    words_n   = words_q;
    cnt_n     = cnt_q;
    sel_n     = sel_q;
    req_n     = req_q;
    granted_n = granted_q;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_n   = PH_FILL;
          words_n   = words_of(len_i);
          cnt_n     = '0;
          sel_n     = '0;
          req_n     = 1'b0;
          granted_n = 1'b0;
        end
      end
      PH_FILL: begin
        if (shift_o)  cnt_n = cnt_q + CW'(1);
        if (pre_hit)  req_n = 1'b1;
        if (gnt_take) begin
          granted_n = 1'b1;
          req_n     = 1'b0;
        end
        if (launch_o) begin
          phase_n   = PH_DRAIN;
          sel_n     = CW'(1);
          req_n     = 1'b0;
          granted_n = 1'b0;
        end
      end
      PH_DRAIN: begin
        if (more)   sel_n   = sel_q + CW'(1);
        if (done_o) phase_n = PH_IDLE;
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      words_q   <= '0;
      cnt_q     <= '0;
      sel_q     <= '0;
      req_q     <= 1'b0;
      granted_q <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      words_q   <= words_n;
      cnt_q     <= cnt_n;
      sel_q     <= sel_n;
      req_q     <= req_n;
      granted_q <= granted_n;
    end
  end

  AST_REQ_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> fill) else $error("request outside fill"); // R4
  AST_REQ_OFF_DIS: assert property (@(posedge clk) disable iff (!rst_n)
    board_dis_i |-> !bus_req_o) else $error("request under disable"); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> cnt_q <= words_q) else $error("buffer overfilled"); // R2
  AST_SHIFT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    shift_o |=> (cnt_q == $past(cnt_q) + CW'(1))) else $error("shift not counted"); // R2
  AST_SEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    drain |-> (sel_q >= CW'(1) && sel_q <= words_q)) else $error("select out of range"); // R6
endmodule

// File: rtl/br_drive.sv
module br_drive #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [DW-1:0] word_i,
  input  logic          flag_i,
  input  logic          set_i,
  input  logic          done_i,
  input  logic          board_dis_i,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_uerr_o
);
  logic [DW-1:0] out_q, out_n;
  logic          flag_q, flag_n;
  logic          en_q, en_n;

  always_comb begin
    out_n  = out_q;
    flag_n = flag_q;
    if (step_i) begin
      out_n  = word_i;
      flag_n = flag_i;
    end
  end

  always_comb begin
    if (board_dis_i)  en_n = 1'b0;
    else if (set_i)   en_n = 1'b1;
    else if (done_i)  en_n = 1'b0;
    else              en_n = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      flag_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      out_q  <= out_n;
      flag_q <= flag_n;
      en_q   <= en_n;
    end
  end

  assign bus_oe_o   = en_q;
  assign bus_data_o = out_q;
  assign bus_uerr_o = flag_q;

  AST_DIS_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(board_dis_i) |-> !bus_oe_o) else $error("drive under disable"); // R7
  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_i) |-> !bus_oe_o) else $error("drive past last word"); // R6
  AST_OE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(step_i)) else $error("enable without fresh word"); // R5
endmodule

// File: rtl/burst_return.sv
module burst_return #(
  parameter int DW    = 64,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    len_i,
  input  logic          pre_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic          ld_uerr_i,
  input  logic          board_dis_i,
  input  logic          bus_gnt_i,
  output logic          bus_req_o,
  output logic          bus_oe_o,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_uerr_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_s;
  logic          shift, step, launch, done, rd_flag;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  br_seq #(.DEPTH(DEPTH), .LENW(2)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s),
    .start_i    (start_i),
    .len_i      (len_i),
    .pre_i      (pre_i),
    .ld_i       (ld_i),
    .board_dis_i(board_dis_i),
    .bus_gnt_i  (bus_gnt_i),
    .shift_o    (shift),
    .bus_req_o  (bus_req_o),
    .rd_idx_o   (rd_idx),
    .step_o     (step),
    .launch_o   (launch),
    .done_o     (done)
  );

  br_shift_buf #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_s),
    .shift_i (shift),
    .din_i   (ld_data_i),
    .dflag_i (ld_uerr_i),
    .rd_idx_i(rd_idx),
    .dout_o  (rd_word),
    .dflag_o (rd_flag)
  );

  br_drive #(.DW(DW)) u_drv (
    .clk        (clk),
    .rst_n      (rst_s),
    .step_i     (step),
    .word_i     (rd_word),
    .flag_i     (rd_flag),
    .set_i      (launch),
    .done_i     (done),
    .board_dis_i(board_dis_i),
    .bus_oe_o   (bus_oe_o),
    .bus_data_o (bus_data_o),
    .bus_uerr_o (bus_uerr_o)
  );
endmodule

// File: tb/sim_burst_return.sv
module sim_burst_return;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, pre_i, ld_i, ld_uerr_i, board_dis_i, bus_gnt_i;
  logic [1:0]  len_i;
  logic [63:0] ld_data_i;
  logic        bus_req_o, bus_oe_o, bus_uerr_o;
  logic [63:0] bus_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  burst_return u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i), .pre_i(pre_i),
    .ld_i(ld_i), .ld_data_i(ld_data_i), .ld_uerr_i(ld_uerr_i),
    .board_dis_i(board_dis_i), .bus_gnt_i(bus_gnt_i), .bus_req_o(bus_req_o),
    .bus_oe_o(bus_oe_o), .bus_data_o(bus_data_o), .bus_uerr_o(bus_uerr_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // gwait < 0: grant in the early-warning cycle of the final word
  task automatic t_burst(input int code, input int gwait, input bit dis,
                         input logic [31:0] seed, input logic [3:0] umask,
                         input bit stray);
    int n;
    n = (code >= 2) ? 4 : (1 << code);
    tick();
    board_dis_i = dis;
    start_i = 1'b1; len_i = 2'(code);
    tick();
    start_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      pre_i = 1'b1;
      #1;
      chk("R4 request with final warning", 64'(bus_req_o), 64'((k == n - 1) && !dis));
      if (k == n - 1 && gwait < 0 && !dis) bus_gnt_i = 1'b1;
      tick();
      pre_i = 1'b0; bus_gnt_i = 1'b0;
      ld_i = 1'b1; ld_data_i = {seed, 32'(k)}; ld_uerr_i = umask[k];
      #1;
      if (k == n - 1 && gwait >= 0 && !dis)
        chk("R4 request held into final load", 64'(bus_req_o), 64'd1);
      tick();
      ld_i = 1'b0;
    end
    if (dis) begin
      for (int c = 0; c < 8; c++) begin
        chk("R7 no request under disable", 64'(bus_req_o), 64'd0);
        chk("R7 no drive under disable", 64'(bus_oe_o), 64'd0);
        tick();
      end
      board_dis_i = 1'b0;
      return;
    end
    if (gwait >= 0) begin
      for (int c = 0; c < gwait; c++) begin
        chk("R4 request held until grant", 64'(bus_req_o), 64'd1);
        chk("R5 no drive before grant", 64'(bus_oe_o), 64'd0);
        tick();
      end
      bus_gnt_i = 1'b1;
      tick();
      bus_gnt_i = 1'b0;
    end else begin
      chk("R5 early grant waits for final word", 64'(bus_oe_o), 64'd0);
      chk("R4 request dropped after grant", 64'(bus_req_o), 64'd0);
      tick();
    end
    for (int k = 0; k < n; k++) begin
      chk("R6 enable during burst", 64'(bus_oe_o), 64'd1);
      chk("R3 word order on bus", bus_data_o, {seed, 32'(k)});
      chk("R8 error flag with word", 64'(bus_uerr_o), 64'(umask[k]));
      if (stray) begin
        ld_i = 1'b1; ld_data_i = 64'hDEAD_BEEF_0000_0000 | 64'(k);
        start_i = 1'b1; len_i = 2'd0;
      end
      tick();
      ld_i = 1'b0; start_i = 1'b0;
    end
    chk("R6 enable drops after last word", 64'(bus_oe_o), 64'd0);
    if (stray) begin
      for (int c = 0; c < 3; c++) begin
        tick();
        chk("R9 start during drain ignored (no drive)", 64'(bus_oe_o), 64'd0);
        pre_i = 1'b1;
        #1;
        chk("R9 start during drain ignored (no request)", 64'(bus_req_o), 64'd0);
        pre_i = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start_i = 0; pre_i = 0; ld_i = 0; ld_uerr_i = 0; board_dis_i = 0; bus_gnt_i = 0;
    len_i = 0; ld_data_i = '0;
    repeat (3) tick();
    chk("R1 reset oe", 64'(bus_oe_o), 64'd0);
    chk("R1 reset req", 64'(bus_req_o), 64'd0);
    chk("R1 reset data", bus_data_o, 64'd0);
    chk("R1 reset flag", 64'(bus_uerr_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 idle oe after release", 64'(bus_oe_o), 64'd0);
  endtask

  task automatic t_stray_idle();
    // R2: loads while idle must not disturb the next burst
    for (int c = 0; c < 3; c++) begin
      ld_i = 1'b1; ld_data_i = 64'hBAD0_0000_0000_0000 | 64'(c); ld_uerr_i = 1'b1;
      tick();
    end
    ld_i = 1'b0; ld_uerr_i = 1'b0;
    t_burst(1, 0, 1'b0, 32'h2222_0002, 4'b0000, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_burst(0, 0, 1'b0, 32'h1111_0001, 4'b0000, 1'b0);
    t_burst(1, 2, 1'b0, 32'h1111_0002, 4'b0010, 1'b0);
    t_burst(2, -1, 1'b0, 32'h1111_0004, 4'b0100, 1'b0);
    t_burst(3, 1, 1'b0, 32'h1111_0003, 4'b1001, 1'b0);
    t_burst(2, 0, 1'b1, 32'h3333_0000, 4'b0000, 1'b0);
    t_burst(1, 0, 1'b0, 32'h1111_0005, 4'b0001, 1'b0);
    t_burst(2, 0, 1'b0, 32'h4444_0000, 4'b1111, 1'b1);
    t_stray_idle();
    t_burst(0, -1, 1'b0, 32'h5555_0000, 4'b0001, 1'b0);
    t_burst(2, 5, 1'b0, 32'h6666_0000, 4'b0000, 1'b0);
    repeat (2) tick();
    finish_run();
  end
endmodule